// File: doc/BRIEF.md
# CAN Mailbox Interrupt Flag Controller

This block keeps the per-mailbox event flags, transmit request bits and interrupt masks for a CAN controller with a parameterised number of mailboxes (32 by default). The bit engine, acceptance filter and message storage are outside the block. They report to it through one-cycle event pulses, one bit per mailbox. There are pulses for a received data frame, a received remote frame, a message overrun, a completed transmission and an aborted transmission.

Software reaches the state through a synchronous write port and a combinational read port, both with 16-bit registers. Each 32-mailbox vector is split across two registers: the even address holds mailboxes 15..0 and the odd address holds mailboxes 31..16. Four registered interrupt-request outputs summarise the unmasked flags.

The mask affects only the interrupt outputs. Status bits still set, transmit requests still retire and abort acknowledges still set on a masked mailbox. The asynchronous active-low reset is released to the internal logic through a two-stage synchroniser.

Top module: `can_mbi_top`

## Requirements
- R1: After reset both mask registers read 0xFFFF, every other register reads 0, and all four interrupt outputs are low.
- R2: Mask registers sit at address 0 (mailboxes 15..0, bit i = mailbox i) and address 1 (bit i = mailbox 16+i). They are plain read/write, and a 1 masks the mailbox.
- R3: The status flags set on their event pulse whether or not the mailbox is masked. Data-received flags are at addresses 2/3, remote-request flags at 4/5 and overrun flags at 6/7, all with the same bit-to-mailbox layout as R2.
- R4: Status flags, abort-acknowledge and empty flags are cleared by writing 1 to the bit, and writing 0 leaves them unchanged. When a set event and a write-1 clear hit one bit in the same cycle, the bit ends up set.
- R5: Transmit-pending (8/9) and transmit-cancel (10/11) bits set when 1 is written and ignore writes of 0. Both clear on a transmit-done or transmit-abort pulse for that mailbox, masked or not. That hardware clear beats a software set in the same cycle.
- R6: An abort pulse sets the abort-acknowledge bit (12/13). A done or abort pulse sets the mailbox-empty bit (14/15). Neither depends on the mask.
- R7: Each of irq_rx_data, irq_rx_remote, irq_overrun and irq_mb_empty is the OR over mailboxes of its flag ANDed with the inverted mask. The output follows one clock after the flag or mask register changes.
- R8: Addresses 16 to 31 read as 0, and writes to them change no register.
- R9: rd_data shows the register selected by rd_addr in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_data | input | NUM_MB | Data frame received pulse per mailbox |
| ev_rx_remote | input | NUM_MB | Remote frame received pulse per mailbox |
| ev_overrun | input | NUM_MB | Overrun pulse per mailbox |
| ev_tx_done | input | NUM_MB | Transmission completed pulse per mailbox |
| ev_tx_abort | input | NUM_MB | Transmission aborted pulse per mailbox |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |
| irq_rx_data | output | 1 | Unmasked data-received request |
| irq_rx_remote | output | 1 | Unmasked remote-request request |
| irq_overrun | output | 1 | Unmasked overrun request |
| irq_mb_empty | output | 1 | Unmasked mailbox-empty request |

## Verification
The bench targets a flag event and a write-1 clear landing in the same cycle. A design that let the clear win would lose a reception. It also targets a transmit completion that coincides with a software request for the same mailbox. Letting the set win there would leave a stale request that resends a finished frame.

Masked mailboxes are checked to still update their status, retire their requests and set their abort acknowledges. A mask that gated the flags instead of the outputs would hide events from software. The bench samples the interrupt outputs in the cycle after a mask or flag change, which catches an output path that is too fast or too slow. Writes to unimplemented addresses are checked against the mask, because a decoder that ignored the upper address bit would alias them onto it.

// File: rtl/can_mbi_pkg.sv
package can_mbi_pkg;
  // Register groups: group g occupies NUM_SEG consecutive addresses.
  localparam int NUM_GRP      = 8;
  localparam int GRP_MASK     = 0;
  localparam int GRP_RXDATA   = 1;
  localparam int GRP_REMOTE   = 2;
  localparam int GRP_OVERRUN  = 3;
  localparam int GRP_TXPEND   = 4;
  localparam int GRP_TXCANCEL = 5;
  localparam int GRP_ABTACK   = 6;
  localparam int GRP_EMPTY    = 7;

  // Sticky flag banks.
  localparam int NUM_FLAG    = 5;
  localparam int FLG_RXDATA  = 0;
  localparam int FLG_REMOTE  = 1;
  localparam int FLG_OVERRUN = 2;
  localparam int FLG_ABTACK  = 3;
  localparam int FLG_EMPTY   = 4;

  // Interrupt request lines.
  localparam int NUM_IRQ     = 4;
  localparam int IRQ_RXDATA  = 0;
  localparam int IRQ_REMOTE  = 1;
  localparam int IRQ_OVERRUN = 2;
  localparam int IRQ_EMPTY   = 3;

  // Register group owning each flag bank.
  function automatic int flag_grp(input int f);
    case (f)
      FLG_RXDATA:  return GRP_RXDATA;
      FLG_REMOTE:  return GRP_REMOTE;
      FLG_OVERRUN: return GRP_OVERRUN;
      FLG_ABTACK:  return GRP_ABTACK;
      default:     return GRP_EMPTY;
    endcase
  endfunction
endpackage

// File: rtl/mbi_rst_sync.sv
module mbi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mbi_flag_bank.sv
// Sticky flags: hardware set, software write-1 clear, set dominates.
module mbi_flag_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_nxt;
  logic         upd;

  always_comb begin
    q_nxt = (q_o & ~clr_i) | set_i;
    upd   = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= '0;
    else if (upd) q_o <= q_nxt;
  end
endmodule

// File: rtl/mbi_tx_req.sv
// Transmit request and cancel bits: software set, retired by done/abort.
module mbi_tx_req #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_set_i,
  input  logic [N-1:0] cancel_set_i,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] abort_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] cancel_o
);
  logic [N-1:0] retire;
  logic [N-1:0] pend_nxt;
  logic [N-1:0] cancel_nxt;
  logic         upd;

  always_comb begin
    retire     = done_i | abort_i;
    // The retire term is applied last, so hardware completion wins.
    pend_nxt   = (pend_o   | pend_set_i)   & ~retire;
    cancel_nxt = (cancel_o | cancel_set_i) & ~retire;
    upd        = |(retire | pend_set_i | cancel_set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o   <= '0;
      cancel_o <= '0;
    end else if (upd) begin
      pend_o   <= pend_nxt;
      cancel_o <= cancel_nxt;
    end
  end
endmodule

// File: rtl/mbi_irq_merge.sv
// Registered masked OR reduction, one request line per source bank.
module mbi_irq_merge #(
  parameter int N = 32,
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i [M],
  input  logic [N-1:0] mask_i,
  output logic [M-1:0] irq_o
);
  logic [M-1:0] irq_nxt;

  always_comb begin
    for (int m = 0; m < M; m++) irq_nxt[m] = |(src_i[m] & ~mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= irq_nxt;
  end
endmodule

// File: rtl/can_mbi_top.sv
module can_mbi_top
  import can_mbi_pkg::*;
#(
  parameter int NUM_MB = 32,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MB-1:0] ev_rx_data,
  input  logic [NUM_MB-1:0] ev_rx_remote,
  input  logic [NUM_MB-1:0] ev_overrun,
  input  logic [NUM_MB-1:0] ev_tx_done,
  input  logic [NUM_MB-1:0] ev_tx_abort,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_rx_data,
  output logic              irq_rx_remote,
  output logic              irq_overrun,
  output logic              irq_mb_empty
);
  localparam int NUM_SEG = NUM_MB / DATA_W;

  logic              rst_sync_n;
  logic [NUM_MB-1:0] grp_wr   [NUM_GRP];
  logic [NUM_MB-1:0] grp_view [NUM_GRP];
  logic [NUM_MB-1:0] flag_set [NUM_FLAG];
  logic [NUM_MB-1:0] flag_q   [NUM_FLAG];
  logic [NUM_MB-1:0] irq_src  [NUM_IRQ];
  logic [NUM_MB-1:0] mask_q;
  logic [NUM_MB-1:0] mask_nxt;
  logic              mask_upd;
  logic [NUM_MB-1:0] txpend_q;
  logic [NUM_MB-1:0] txcancel_q;
  logic [NUM_IRQ-1:0] irq_q;

  mbi_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Write decode: per group, the write-1 vector across all mailboxes.
  // Full address compare, so addresses beyond the map hit nothing.
  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) grp_wr[g] = '0;
    if (wr_en) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        for (int s = 0; s < NUM_SEG; s++) begin
          if (wr_addr == ADDR_W'(g * NUM_SEG + s))
            grp_wr[g][s*DATA_W +: DATA_W] = wr_data;
        end
      end
    end
  end

  // Mask register: plain read/write, reset to all masked.
  always_comb begin
    mask_nxt = mask_q;
    mask_upd = 1'b0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (wr_en && (wr_addr == ADDR_W'(GRP_MASK * NUM_SEG + s))) begin
        mask_nxt[s*DATA_W +: DATA_W] = wr_data;
        mask_upd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   mask_q <= '1;
    else if (mask_upd) mask_q <= mask_nxt;
  end

  // Hardware set sources per flag bank; the mask is not involved.
  always_comb begin
    flag_set[FLG_RXDATA]  = ev_rx_data;
    flag_set[FLG_REMOTE]  = ev_rx_remote;
    flag_set[FLG_OVERRUN] = ev_overrun;
    flag_set[FLG_ABTACK]  = ev_tx_abort;
    flag_set[FLG_EMPTY]   = ev_tx_done | ev_tx_abort;
  end

  for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
    localparam int GRP = flag_grp(f);
    mbi_flag_bank #(.N(NUM_MB)) u_bank (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (flag_set[f]),
      .clr_i (grp_wr[GRP]),
      .q_o   (flag_q[f])
    );
  end

  mbi_tx_req #(.N(NUM_MB)) u_tx_req (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .pend_set_i   (grp_wr[GRP_TXPEND]),
    .cancel_set_i (grp_wr[GRP_TXCANCEL]),
    .done_i       (ev_tx_done),
    .abort_i      (ev_tx_abort),
    .pend_o       (txpend_q),
    .cancel_o     (txcancel_q)
  );

  always_comb begin
    irq_src[IRQ_RXDATA]  = flag_q[FLG_RXDATA];
    irq_src[IRQ_REMOTE]  = flag_q[FLG_REMOTE];
    irq_src[IRQ_OVERRUN] = flag_q[FLG_OVERRUN];
    irq_src[IRQ_EMPTY]   = flag_q[FLG_EMPTY];
  end

  mbi_irq_merge #(.N(NUM_MB), .M(NUM_IRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .src_i  (irq_src),
    .mask_i (mask_q),
    .irq_o  (irq_q)
  );

  assign irq_rx_data   = irq_q[IRQ_RXDATA];
  assign irq_rx_remote = irq_q[IRQ_REMOTE];
  assign irq_overrun   = irq_q[IRQ_OVERRUN];
  assign irq_mb_empty  = irq_q[IRQ_EMPTY];

  // Read view and combinational read mux; unmapped addresses give 0.
  always_comb begin
    grp_view[GRP_MASK]     = mask_q;
    grp_view[GRP_RXDATA]   = flag_q[FLG_RXDATA];
    grp_view[GRP_REMOTE]   = flag_q[FLG_REMOTE];
    grp_view[GRP_OVERRUN]  = flag_q[FLG_OVERRUN];
    grp_view[GRP_TXPEND]   = txpend_q;
    grp_view[GRP_TXCANCEL] = txcancel_q;
    grp_view[GRP_ABTACK]   = flag_q[FLG_ABTACK];
    grp_view[GRP_EMPTY]    = flag_q[FLG_EMPTY];
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int s = 0; s < NUM_SEG; s++) begin
        if (rd_addr == ADDR_W'(g * NUM_SEG + s))
          rd_data = grp_view[g][s*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/can_mbi_chk.sv
module can_mbi_chk #(
  parameter int NUM_MB = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_MB-1:0] ev_rx_remote,
  input logic [NUM_MB-1:0] ev_tx_done,
  input logic [NUM_MB-1:0] ev_tx_abort,
  input logic [NUM_MB-1:0] mask_q,
  input logic [NUM_MB-1:0] remote_q,
  input logic [NUM_MB-1:0] txpend_q,
  input logic [NUM_MB-1:0] txcancel_q,
  input logic [NUM_MB-1:0] abtack_q,
  input logic [NUM_MB-1:0] empty_q,
  input logic [3:0]        irq_q
);
  // R1: the first cycle out of reset sees every mailbox masked
  a_r1_mask_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (&mask_q));

  // R3: remote pulse sets the flag regardless of mask
  a_r3_remote_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_remote != '0) |=> ((remote_q & $past(ev_rx_remote)) == $past(ev_rx_remote)));

  // R5: done or abort retires request and cancel bits
  a_r5_tx_retire: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_tx_done | ev_tx_abort) != '0) |=>
      (((txpend_q | txcancel_q) & $past(ev_tx_done | ev_tx_abort)) == '0));

  // R6: abort pulse sets abort acknowledge
  a_r6_abort_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_abort != '0) |=> ((abtack_q & $past(ev_tx_abort)) == $past(ev_tx_abort)));

  // R6: done or abort sets mailbox empty
  a_r6_empty_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_tx_done | ev_tx_abort) != '0) |=>
      ((empty_q & $past(ev_tx_done | ev_tx_abort)) == $past(ev_tx_done | ev_tx_abort)));

  // R7: a fully masked block raises no request next cycle
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> (irq_q == 4'b0000));
endmodule

bind can_mbi_top can_mbi_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ev_rx_remote (ev_rx_remote),
  .ev_tx_done   (ev_tx_done),
  .ev_tx_abort  (ev_tx_abort),
  .mask_q       (mask_q),
  .remote_q     (flag_q[can_mbi_pkg::FLG_REMOTE]),
  .txpend_q     (txpend_q),
  .txcancel_q   (txcancel_q),
  .abtack_q     (flag_q[can_mbi_pkg::FLG_ABTACK]),
  .empty_q      (flag_q[can_mbi_pkg::FLG_EMPTY]),
  .irq_q        (irq_q)
);

// File: tb/tb_can_mbi_top.sv
`timescale 1ns/1ps
module tb_can_mbi_top;
  localparam int NUM_MB = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  logic clk;
  logic rst_n;
  logic [NUM_MB-1:0] ev_rx_data, ev_rx_remote, ev_overrun, ev_tx_done, ev_tx_abort;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic irq_rx_data, irq_rx_remote, irq_overrun, irq_mb_empty;

  can_mbi_top #(.NUM_MB(NUM_MB), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_data(ev_rx_data), .ev_rx_remote(ev_rx_remote), .ev_overrun(ev_overrun),
    .ev_tx_done(ev_tx_done), .ev_tx_abort(ev_tx_abort),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_rx_data(irq_rx_data), .irq_rx_remote(irq_rx_remote),
    .irq_overrun(irq_overrun), .irq_mb_empty(irq_mb_empty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    bit              is_irq;
    logic [ADDR_W-1:0] addr;
    logic [15:0]     exp;
    string           tag;
  } item_t;

  item_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Monitor: pops expected items and compares with what the design shows.
  initial begin
    forever begin
      item_t it;
      logic [15:0] got;
      wait (sbq.size() != 0);
      it = sbq[0];
      if (it.is_irq) begin
        #1;
        got = {12'h000, irq_mb_empty, irq_overrun, irq_rx_remote, irq_rx_data};
      end else begin
        rd_addr = it.addr;
        #1;
        got = rd_data;
      end
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: addr=%0d got=%h expected=%h", it.tag, it.addr, got, it.exp);
      end
      void'(sbq.pop_front());
    end
  end

  // Driver side: queue an expectation and wait until the monitor consumed it.
  task automatic exp_reg(input int a, input logic [15:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.addr = ADDR_W'(a); it.exp = e; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  // irq vector order: {mb_empty, overrun, rx_remote, rx_data}
  task automatic exp_irq(input logic [3:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.addr = '0; it.exp = {12'h000, e}; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 1'b0;
    ev_rx_data = '0; ev_rx_remote = '0; ev_overrun = '0;
    ev_tx_done = '0; ev_tx_abort = '0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    step();
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    ev_rx_data = '0; ev_rx_remote = '0; ev_overrun = '0;
    ev_tx_done = '0; ev_tx_abort = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    exp_reg(0, 16'hFFFF, "R1 mask lo");
    exp_reg(1, 16'hFFFF, "R1 mask hi");
    for (int a = 2; a < 16; a++) exp_reg(a, 16'h0000, "R1 clear regs");
    exp_irq(4'b0000, "R1 irq idle");
    // R8: unmapped read
    exp_reg(20, 16'h0000, "R8 unmapped read");

    // R3: data events on masked mailboxes 3 and 20 still set flags
    ev_rx_data[3] = 1'b1; ev_rx_data[20] = 1'b1;
    step();
    exp_reg(2, 16'h0008, "R3 rx lo");
    exp_reg(3, 16'h0010, "R3 rx hi mb20");
    step();
    exp_irq(4'b0000, "R7 masked rx quiet");

    // R2 / R7: unmask mailbox 3, irq follows one cycle later
    wr(0, 16'hFFF7);
    exp_reg(0, 16'hFFF7, "R2 mask readback");
    exp_irq(4'b0000, "R7 latency after mask");
    step();
    exp_irq(4'b0001, "R7 rx irq");

    // R4: write 0 no effect, write 1 clears
    wr(2, 16'h0000);
    exp_reg(2, 16'h0008, "R4 write0 keeps");
    wr(2, 16'h0008);
    exp_reg(2, 16'h0000, "R4 w1c");
    step();
    exp_irq(4'b0000, "R7 irq drops");

    // R4: same-cycle set and clear, set wins
    ev_rx_data[3] = 1'b1;
    wr(2, 16'h0008);
    exp_reg(2, 16'h0008, "R4 set wins");
    step();
    exp_irq(4'b0001, "R7 irq after set wins");
    wr(2, 16'h0008);
    exp_reg(2, 16'h0000, "R4 clear after");

    // R3 / R7: remote and overrun on mailbox 17
    wr(1, 16'hFFFD);
    step();
    ev_rx_remote[17] = 1'b1;
    step();
    exp_reg(5, 16'h0002, "R3 remote hi");
    exp_irq(4'b0000, "R7 remote latency");
    step();
    exp_irq(4'b0010, "R7 remote irq");
    ev_overrun[17] = 1'b1;
    step();
    exp_reg(7, 16'h0002, "R3 overrun hi");
    step();
    exp_irq(4'b0110, "R7 overrun irq");
    wr(5, 16'h0002);
    wr(7, 16'h0002);
    step();
    exp_irq(4'b0000, "R4 flags cleared irq");

    // R5: transmit requests
    wr(8, 16'h0030);
    wr(9, 16'h8000);
    exp_reg(8, 16'h0030, "R5 pend lo");
    exp_reg(9, 16'h8000, "R5 pend hi");
    wr(9, 16'h0000);
    exp_reg(9, 16'h8000, "R5 write0 keeps pend");
    wr(10, 16'h0020);
    exp_reg(10, 16'h0020, "R5 cancel set");

    // R5 / R6: done on masked mailbox 4
    ev_tx_done[4] = 1'b1;
    step();
    exp_reg(8, 16'h0020, "R5 done clears pend");
    exp_reg(14, 16'h0010, "R6 empty on done");
    exp_reg(12, 16'h0000, "R6 no ack on done");
    step();
    exp_irq(4'b0000, "R7 masked empty quiet");

    // R5 / R6: abort on masked mailbox 5
    ev_tx_abort[5] = 1'b1;
    step();
    exp_reg(8, 16'h0000, "R5 abort clears pend");
    exp_reg(10, 16'h0000, "R5 abort clears cancel");
    exp_reg(12, 16'h0020, "R6 abort ack");
    exp_reg(14, 16'h0030, "R6 empty on abort");

    // R5: hardware completion beats software set
    ev_tx_done[31] = 1'b1;
    wr(9, 16'h8000);
    exp_reg(9, 16'h0000, "R5 hw clear wins");
    exp_reg(15, 16'h8000, "R6 empty hi");
    wr(1, 16'h7FFD);
    exp_irq(4'b0000, "R7 empty latency");
    step();
    exp_irq(4'b1000, "R7 empty irq");
    wr(15, 16'h8000);
    step();
    exp_irq(4'b0000, "R7 empty cleared");
    exp_reg(15, 16'h0000, "R4 empty w1c");

    // R8: unmapped write ignored
    wr(16, 16'hFFFF);
    exp_reg(16, 16'h0000, "R8 unmapped stays 0");
    exp_reg(0, 16'hFFF7, "R8 no alias mask lo");
    exp_reg(1, 16'h7FFD, "R8 no alias mask hi");
    exp_reg(31, 16'h0000, "R8 top address");

    // R4: abort acknowledge clear
    wr(12, 16'h0020);
    exp_reg(12, 16'h0000, "R4 abort ack w1c");

    // R9: read mux switches without a clock edge
    exp_reg(3, 16'h0010, "R9 comb read a");
    exp_reg(14, 16'h0030, "R9 comb read b");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule